// File: doc/BRIEF.md
# Data-Polling Completion Checker

This block sits on the host side of a parallel flash interface. After the host has finished a program or erase command sequence, it hands the block one start request carrying the operation type, the status address and the expected byte. The block then reads the memory at that address over and over, one read at a time, until bit 7 of the returned byte shows the true value. For a program, the true value is bit 7 of the written byte. For an erase, it is 1.

Bit 7 can flip before the lower bits have settled. For that reason, a detected flip is never taken as the final answer. The block always issues one more read and judges the whole byte from that read. It reports the outcome as success, verify failure or timeout, together with the byte it used. A poll budget bounds how long it waits. The result stays on the outputs until the host acknowledges it, and no new operation is accepted in the meantime.

Top module: `dpoll_checker`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `fail` and `rd_req` are 0.
- R2: A start request is taken only when the block is idle. No read is requested in the cycle the start is taken, and the first read request appears in the very next cycle.
- R3: Every read request carries the address given with the start. At most one read is outstanding: no new `rd_req` is raised until `rd_valid` has returned the previous read.
- R4: For a program (`start_erase`=0), polling ends when bit 7 of the returned byte equals bit 7 of `start_data`.
- R5: For an erase (`start_erase`=1), polling ends when bit 7 of the returned byte is 1. `start_data` is ignored and the expected byte is all ones.
- R6: After polling ends, exactly one confirming read is issued before the result is raised, and `result_data` is the byte from that read.
- R7: `result_code` is 0 (success) when the confirming byte equals the expected byte and 1 (verify failure) otherwise. `fail` is 1 exactly when `done` is 1 and `result_code` is not 0.
- R8: If `MAX_POLLS` polls complete without the true value, the block reports `result_code` 2 (timeout) with `fail`=1 and `result_data` equal to the last polled byte, after exactly `MAX_POLLS` reads. If the true value arrives on poll number `MAX_POLLS`, the operation still completes normally.
- R9: `done`, `fail`, `result_code` and `result_data` hold until `result_ack` is sampled high. While they hold, `start_valid` is ignored and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request, taken when idle |
| start_erase | input | 1 | 1 = erase operation, 0 = program operation |
| start_addr | input | AW | Status address to poll |
| start_data | input | DW | Byte that was programmed (unused for erase) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Byte returned by the memory |
| rd_valid | input | 1 | `rd_data` is valid for the outstanding read |
| done | output | 1 | Result available |
| fail | output | 1 | Result is a failure |
| result_code | output | 2 | 0 success, 1 verify failure, 2 timeout |
| result_data | output | DW | Confirming byte, or last polled byte on timeout |
| result_ack | input | 1 | Host acknowledges the result |

## Verification
The assertions check four things on every cycle:
- A read request is never raised in two consecutive cycles.
- The read address does not move while a read is answered.
- The poll counter stays below its limit.
- A held result stays frozen until it is acknowledged, and a success is only ever raised straight out of a confirming read.

Only the bench scenarios can show the rest:
- Which bit-7 value ends polling for each operation type.
- That the confirming byte, and not the flip byte, decides the outcome.
- That the exact number of reads matches the poll count, including completion on the final allowed poll.
- That a timeout occurs and reports the last polled byte.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_POLL_REQ  = 3'd1,
    ST_POLL_WAIT = 3'd2,
    ST_CONF_REQ  = 3'd3,
    ST_CONF_WAIT = 3'd4,
    ST_DONE      = 3'd5
  } dp_state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_VERIFY  = 2'd1,
    RES_TIMEOUT = 2'd2
  } dp_result_e;

endpackage

// File: rtl/dpoll_match.sv
// Compares a returned byte with the expected byte: the status bit alone and the whole byte.
module dpoll_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] target,
  output logic          flag_true,
  output logic          byte_equal
);

  localparam int FLAG_BIT = DW - 1;

  always_comb begin
    flag_true  = (sample[FLAG_BIT] == target[FLAG_BIT]);
    byte_equal = (sample == target);
  end

endmodule

// File: rtl/dpoll_budget.sv
// Counts busy polls and flags the last one allowed.
module dpoll_budget #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    last   = (cnt_q == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_BUDGET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LIMIT)) else $error("poll counter past limit"); // R8

endmodule

// File: rtl/dpoll_ctrl.sv
// Sequencer: poll until the status bit is true, one confirming read, then hold the result.
module dpoll_ctrl
  import dpoll_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          flag_true,
  input  logic          byte_equal,
  input  logic          budget_last,
  input  logic          result_ack,
  output logic          accept,
  output logic          rd_req,
  output logic          budget_inc,
  output logic          done,
  output logic          fail,
  output logic [1:0]    result_code,
  output logic [DW-1:0] result_data
);

  dp_state_e     state_q, state_d;
  dp_result_e    code_q, code_d;
  logic [DW-1:0] data_q;
  logic          cap_en;

  always_comb begin
    state_d    = state_q;
    code_d     = code_q;
    cap_en     = 1'b0;
    accept     = 1'b0;
    rd_req     = 1'b0;
    budget_inc = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_valid) begin
          accept  = 1'b1;
          state_d = ST_POLL_REQ;
        end
      end
      ST_POLL_REQ: begin
        rd_req  = 1'b1;
        state_d = ST_POLL_WAIT;
      end
      ST_POLL_WAIT: begin
        if (rd_valid) begin
          if (flag_true) begin
            state_d = ST_CONF_REQ;
          end else if (budget_last) begin
            cap_en  = 1'b1;
            code_d  = RES_TIMEOUT;
            state_d = ST_DONE;
          end else begin
            budget_inc = 1'b1;
            state_d    = ST_POLL_REQ;
          end
        end
      end
      ST_CONF_REQ: begin
        rd_req  = 1'b1;
        state_d = ST_CONF_WAIT;
      end
      ST_CONF_WAIT: begin
        if (rd_valid) begin
          cap_en  = 1'b1;
          code_d  = byte_equal ? RES_OK : RES_VERIFY;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (result_ack) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RES_OK;
      data_q <= '0;
    end else if (cap_en) begin
      code_q <= code_d;
      data_q <= rd_data;
    end
  end

  always_comb begin
    done        = (state_q == ST_DONE);
    fail        = done && (code_q != RES_OK);
    result_code = code_q;
    result_data = data_q;
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req) else $error("back-to-back read requests"); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !result_ack) |=> (done && $stable(result_code) && $stable(result_data)))
    else $error("result changed before acknowledge"); // R9

  AST_OK_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && (result_code == RES_OK)) |-> $past(state_q == ST_CONF_WAIT))
    else $error("success without confirming read"); // R6

endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker #(
  parameter int AW        = 22,
  parameter int DW        = 8,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic          start_erase,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          done,
  output logic          fail,
  output logic [1:0]    result_code,
  output logic [DW-1:0] result_data,
  input  logic          result_ack
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] target_q, target_d;
  logic          accept;
  logic          flag_true, byte_equal;
  logic          budget_inc, budget_last;

  always_comb begin
    target_d = start_erase ? {DW{1'b1}} : start_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      target_q <= '0;
    end else if (accept) begin
      addr_q   <= start_addr;
      target_q <= target_d;
    end
  end

  assign rd_addr = addr_q;

  dpoll_match #(.DW(DW)) u_match (
    .sample     (rd_data),
    .target     (target_q),
    .flag_true  (flag_true),
    .byte_equal (byte_equal)
  );

  dpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (budget_inc),
    .last  (budget_last)
  );

  dpoll_ctrl #(.DW(DW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .flag_true   (flag_true),
    .byte_equal  (byte_equal),
    .budget_last (budget_last),
    .result_ack  (result_ack),
    .accept      (accept),
    .rd_req      (rd_req),
    .budget_inc  (budget_inc),
    .done        (done),
    .fail        (fail),
    .result_code (result_code),
    .result_data (result_data)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $stable(rd_addr)) else $error("read address moved under a read"); // R3

  AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done) else $error("fail without done"); // R7

endmodule

// File: tb/sim_dpoll_checker.sv
module sim_dpoll_checker;

  localparam int AW  = 22;
  localparam int DW  = 8;
  localparam int MAXP = 6;
  localparam int LAT = 2;

  typedef struct {
    logic [1:0]    code;
    logic [DW-1:0] data;
    int            reads;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_erase = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_data = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          rd_valid = 1'b0;
  logic          done, fail;
  logic [1:0]    result_code;
  logic [DW-1:0] result_data;
  logic          result_ack = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit hold_ack = 0;
  bit reported = 0;
  exp_t exp_q[$];

  // memory model scenario
  logic [AW-1:0] cur_addr;
  int            busy_n, read_idx, delay;
  logic [DW-1:0] busy_b, flip_b, final_b;

  always #2 clk = ~clk;

  dpoll_checker #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_erase(start_erase),
    .start_addr(start_addr), .start_data(start_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .fail(fail),
    .result_code(result_code), .result_data(result_data), .result_ack(result_ack)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (rst_n) begin
      if (rd_req) begin
        check(delay == 0, "R3 read raised while one outstanding", delay, 0);
        check(rd_addr == cur_addr, "R3 read address", rd_addr, cur_addr);
        delay = LAT;
      end else if (delay > 0) begin
        delay--;
        if (delay == 0) begin
          rd_valid = 1'b1;
          rd_data  = (read_idx < busy_n) ? busy_b : (read_idx == busy_n) ? flip_b : final_b;
          read_idx++;
        end
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !reported) begin
        reported = 1;
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected result", result_code, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(result_code == e.code, {e.tag, " code"}, result_code, e.code);
          check(result_data == e.data, {e.tag, " data"}, result_data, e.data);
          check(read_idx == e.reads, {e.tag, " read count"}, read_idx, e.reads);
          check(fail == (e.code != 2'd0), "R7 fail flag", fail, e.code != 2'd0);
        end
      end
      if (!done) begin
        reported = 0;
        result_ack = 1'b0;
      end else begin
        result_ack = (reported && !hold_ack);
      end
    end
  end

  task automatic run_case(input bit erase, input logic [AW-1:0] addr, input logic [DW-1:0] data,
                          input int busy, input logic [DW-1:0] bb, input logic [DW-1:0] fb,
                          input logic [DW-1:0] lb, input string tag);
    exp_t e;
    logic [DW-1:0] tgt;
    tgt = erase ? {DW{1'b1}} : data;
    if (busy >= MAXP) begin
      e.code = 2'd2; e.data = bb; e.reads = MAXP;
    end else begin
      e.code = (lb == tgt) ? 2'd0 : 2'd1; e.data = lb; e.reads = busy + 2;
    end
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    cur_addr = addr; busy_n = busy; busy_b = bb; flip_b = fb; final_b = lb; read_idx = 0;
    start_valid = 1'b1; start_erase = erase; start_addr = addr; start_data = data;
    check(rd_req == 1'b0, "R2 no read in accept cycle", rd_req, 0);
    @(negedge clk);
    start_valid = 1'b0;
    check(rd_req == 1'b1, "R2 first read next cycle", rd_req, 1);
  endtask

  task automatic wait_finish();
    while (!done) @(negedge clk);
    while (done) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    delay = 0; read_idx = 0; busy_n = 0; cur_addr = '0;
    busy_b = '0; flip_b = '0; final_b = '0;
    repeat (3) @(negedge clk);
    check(done == 0 && fail == 0 && rd_req == 0, "R1 outputs in reset", {done, fail, rd_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 0 && fail == 0 && rd_req == 0, "R1 outputs after reset", {done, fail, rd_req}, 0);

    // R4 program with bit7=1, status bit flips before low bits settle (R6)
    run_case(0, 22'h01234, 8'hA5, 3, 8'h25, 8'h81, 8'hA5, "R4 R6 program bit7=1");
    wait_finish();
    // R4 program with bit7=0, true on first poll
    run_case(0, 22'h3FFFF, 8'h3C, 0, 8'hC3, 8'h7F, 8'h3C, "R4 program bit7=0 first poll");
    wait_finish();
    // R5 erase: start_data ignored, expected all ones
    run_case(1, 22'h20000, 8'h12, 4, 8'h00, 8'h80, 8'hFF, "R5 erase");
    wait_finish();
    // R7 program verify failure
    run_case(0, 22'h00555, 8'h96, 1, 8'h16, 8'h80, 8'h94, "R7 program verify fail");
    wait_finish();
    // R7 erase verify failure
    run_case(1, 22'h10000, 8'hFF, 2, 8'h7F, 8'hC0, 8'hEF, "R7 erase verify fail");
    wait_finish();
    // R8 timeout on program
    run_case(0, 22'h00AAA, 8'h55, 100, 8'hAA, 8'h55, 8'h55, "R8 program timeout");
    wait_finish();
    // R8 completion on the last allowed poll
    run_case(1, 22'h30000, 8'h00, MAXP - 1, 8'h40, 8'h80, 8'hFF, "R8 done on last poll");
    wait_finish();
    // R8 erase timeout exactly at budget
    run_case(1, 22'h30001, 8'h00, MAXP, 8'h0F, 8'h80, 8'hFF, "R8 erase timeout");
    wait_finish();

    // R9 hold result and ignore start until acknowledged
    hold_ack = 1;
    run_case(0, 22'h00F0F, 8'h5A, 1, 8'hDA, 8'h5A, 8'h5A, "R9 held result");
    while (!done) @(negedge clk);
    @(negedge clk);
    start_valid = 1'b1; start_addr = 22'h11111; start_data = 8'h00; start_erase = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rd_req == 1'b0, "R9 no read while held", rd_req, 0);
      check(done && result_code == 2'd0 && result_data == 8'h5A, "R9 result held",
            {done, result_code, result_data}, {1'b1, 2'd0, 8'h5A});
    end
    start_valid = 1'b0;
    hold_ack = 0;
    while (done) @(negedge clk);
    @(negedge clk);
    check(rd_req == 1'b0 && done == 1'b0, "R9 idle after ack, ignored start left no trace",
          {rd_req, done}, 0);

    // R2 back-to-back start after ack works
    run_case(0, 22'h00001, 8'h01, 0, 8'h81, 8'h01, 8'h01, "R2 R4 restart");
    wait_finish();

    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule